// File: doc/BRIEF.md
# Two-Wire Acquisition Command Slave

This block is the serial command port of an eight-channel, 12-bit acquisition front end. It listens on a two-wire bus as a slave only and follows the bus's START and STOP framing. It answers a 7-bit address made of a fixed upper nibble and three strap pins. In a write cycle it takes a control byte that selects the channel, the range, the polarity and the power mode. In a read cycle it returns the latest conversion result, left-justified in two bytes.

A conversion sequencer sits beside it. It reads the decoded configuration. It starts input tracking on a pulse that fires as soon as the polarity bit of a valid control byte has been clocked in, which is before that byte is complete. It starts the conversion on a pulse issued at the STOP that closes the cycle. The sequencer loads each finished 12-bit result through a load strobe. SCL and SDA are brought into the system clock through two flip-flops each, so the system clock must run at least eight times faster than SCL.

Top module: `daq_cmd_slave`

## Requirements
- R1: After reset the channel, range and bipolar outputs are 0, the power mode is 0 (normal), SDA is released, and a read returns the bytes 0x00 and 0x00.
- R2: An address byte whose upper 7 bits equal {0101, strap[2:0]} is acknowledged by pulling SDA low during the 9th clock, and `ev_addr` pulses exactly once for it. Bit 0 of the address byte is the direction: 0 means write, 1 means read.
- R3: An address that does not match gets no acknowledge and no `ev_addr`. The block then ignores the bus until the next START, so bytes that follow are not acknowledged and do not change the configuration.
- R4: A control byte with bit 7 set is acknowledged. It updates chan from bits 6:4, range from bit 3 and bipolar from bit 2.
- R5: Control bits 1:0 give the power mode, output as cfg_pwr: 00 or 01 gives 0 (normal), 10 gives 1 (standby), and 11 gives 2 (full power-down).
- R6: A control byte with bit 7 clear is acknowledged. It leaves the configuration unchanged, produces no tracking pulse, and causes no conversion start at the next STOP.
- R7: For a valid control byte, `ev_track` pulses exactly once. The pulse comes after SCL has sampled bit 2 and before bit 1 is sampled.
- R8: Every STOP produces one `ev_stop` pulse. `conv_start` pulses in the same cycle only if a valid control byte was accepted since the previous STOP.
- R9: A read is acknowledged and returns result[11:4], then {result[3:0], 0000}, MSB first. The result is the value last captured by `result_load`.
- R10: During a read, the master's acknowledge bit is ignored, so the second byte is sent after either an ACK or a NACK. Bytes clocked after the second one read as 0xFF, because SDA is released.
- R11: The result is frozen when the read address is matched. A `result_load` during the read changes only the reads that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| strap | input | 3 | Low three address bits |
| result_data | input | 12 | Conversion result from the sequencer |
| result_load | input | 1 | Captures result_data into the output register |
| cfg_chan | output | 3 | Selected input channel |
| cfg_range | output | 1 | Range select bit |
| cfg_bipolar | output | 1 | 1 for bipolar conversion |
| cfg_pwr | output | 2 | 0 normal, 1 standby, 2 full power-down |
| ev_addr | output | 1 | Pulse on address match |
| ev_track | output | 1 | Pulse when the polarity bit of a valid control byte is latched |
| ev_stop | output | 1 | Pulse on every STOP |
| conv_start | output | 1 | Pulse at STOP after a valid control byte |

## Verification
The bench targets these corner cases:

- **Mismatched address.** It follows one with a control byte. A design that kept decoding after a mismatch would acknowledge that byte or change the configuration.
- **Control byte with bit 7 clear.** A design that ignored the start marker would update the configuration or start a conversion.
- **Position of the tracking pulse.** It is checked between bit 2 and bit 1. A pulse tied to the end of the byte falls outside that window.
- **Reads with a master NACK, an over-long read, and a result load during a read.** A design that stopped after a NACK, kept shifting stale data, or read the live result register would return wrong bytes.

// File: rtl/daq_pkg.sv
package daq_pkg;
  typedef enum logic [1:0] {
    PWR_NORMAL  = 2'd0,
    PWR_STANDBY = 2'd1,
    PWR_FULL    = 2'd2
  } pwr_mode_e;

  typedef struct packed {
    logic [2:0] chan;
    logic       range;
    logic       bipolar;
    pwr_mode_e  pwr;
  } daq_cfg_t;

  localparam logic [3:0] ADDR_NIBBLE = 4'b0101;
endpackage

// File: rtl/daq_line_sync.sv
module daq_line_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {(STAGES+1){RST_VAL}};
    else     chain <= {chain[STAGES-1:0], din};
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/daq_ctrl_decode.sv
module daq_ctrl_decode
  import daq_pkg::*;
(
  input  logic [7:0] ctrl_byte,
  output daq_cfg_t   cfg
);
  always_comb begin
    cfg.chan    = ctrl_byte[6:4];
    cfg.range   = ctrl_byte[3];
    cfg.bipolar = ctrl_byte[2];
    unique case (ctrl_byte[1:0])
      2'b10:   cfg.pwr = PWR_STANDBY;
      2'b11:   cfg.pwr = PWR_FULL;
      default: cfg.pwr = PWR_NORMAL;
    endcase
  end
endmodule

// File: rtl/daq_link_fsm.sv
module daq_link_fsm
  import daq_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  logic             sda_rise,
  input  logic             sda_fall,
  input  logic [2:0]       strap,
  input  logic [RES_W-1:0] rd_word,
  output logic             sda_oe,
  output logic             ev_addr,
  output logic             ev_track,
  output logic             ev_stop,
  output logic             conv_start,
  output logic             ctrl_we,
  output logic [7:0]       ctrl_byte,
  output logic             rd_capture
);
  localparam int PAD = 16 - RES_W;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WR, ST_RD} st_e;

  st_e        state;
  logic [3:0] bitcnt;
  logic [6:0] shreg;
  logic [1:0] byte_idx;
  logic       conv_pend;

  logic        start_c, stop_c;
  logic [15:0] frame;
  logic [3:0]  tx_sel;
  logic        tx_bit;
  logic [7:0]  rx_byte;

  assign start_c = scl_lvl & sda_fall;
  assign stop_c  = scl_lvl & sda_rise;
  assign frame   = {rd_word, {PAD{1'b0}}};
  assign tx_sel  = {byte_idx[0], bitcnt[2:0]};
  assign tx_bit  = (byte_idx < 2'd2) ? frame[~tx_sel] : 1'b1;
  assign rx_byte = {shreg, sda_lvl};

  always_ff @(posedge clk) begin
    ev_addr    <= 1'b0;
    ev_track   <= 1'b0;
    ev_stop    <= 1'b0;
    conv_start <= 1'b0;
    ctrl_we    <= 1'b0;
    rd_capture <= 1'b0;
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      byte_idx  <= '0;
      conv_pend <= 1'b0;
      sda_oe    <= 1'b0;
      ctrl_byte <= '0;
    end else if (start_c) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state      <= ST_IDLE;
      sda_oe     <= 1'b0;
      ev_stop    <= 1'b1;
      conv_start <= conv_pend;
      conv_pend  <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (bitcnt == 4'd8) begin
          bitcnt <= '0;
          if (state == ST_ADDR) state <= shreg[0] ? ST_RD : ST_WR;
          if (state == ST_RD && byte_idx != 2'd2) byte_idx <= byte_idx + 2'd1;
        end else begin
          bitcnt <= bitcnt + 4'd1;
          shreg  <= rx_byte[6:0];
          case (state)
            ST_ADDR: if (bitcnt == 4'd7) begin
              if (rx_byte[7:1] == {ADDR_NIBBLE, strap}) begin
                ev_addr    <= 1'b1;
                rd_capture <= sda_lvl;
                byte_idx   <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_WR: begin
              if (bitcnt == 4'd5 && shreg[4]) ev_track <= 1'b1;
              if (bitcnt == 4'd7) begin
                ctrl_byte <= rx_byte;
                ctrl_we   <= shreg[6];
                if (shreg[6]) conv_pend <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end else if (scl_fall) begin
        if (state == ST_RD) sda_oe <= (bitcnt != 4'd8) && !tx_bit;
        else                sda_oe <= (bitcnt == 4'd8);
      end
    end
  end

  // R8
  conv_at_stop_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> ev_stop);
  // R7
  track_single_chk: assert property (@(posedge clk) disable iff (rst)
    ev_track |=> !ev_track);
  // R2
  addr_single_chk: assert property (@(posedge clk) disable iff (rst)
    ev_addr |=> !ev_addr);
  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |=> !sda_oe);
endmodule

// File: rtl/daq_cmd_slave.sv
module daq_cmd_slave
  import daq_pkg::*;
#(
  parameter int RES_W    = 12,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [2:0]       strap,
  input  logic [RES_W-1:0] result_data,
  input  logic             result_load,
  output logic [2:0]       cfg_chan,
  output logic             cfg_range,
  output logic             cfg_bipolar,
  output logic [1:0]       cfg_pwr,
  output logic             ev_addr,
  output logic             ev_track,
  output logic             ev_stop,
  output logic             conv_start
);
  logic [1:0] bus_in, b_lvl, b_rise, b_fall;
  assign bus_in = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    daq_line_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst(rst), .din(bus_in[g]),
      .lvl(b_lvl[g]), .rise(b_rise[g]), .fall(b_fall[g]));
  end

  logic             ctrl_we, rd_capture;
  logic [7:0]       ctrl_byte;
  logic [RES_W-1:0] result_q, rd_word;
  daq_cfg_t         cfg_d, cfg_q;

  daq_link_fsm #(.RES_W(RES_W)) u_fsm (
    .clk(clk), .rst(rst),
    .scl_lvl(b_lvl[0]), .scl_rise(b_rise[0]), .scl_fall(b_fall[0]),
    .sda_lvl(b_lvl[1]), .sda_rise(b_rise[1]), .sda_fall(b_fall[1]),
    .strap(strap), .rd_word(rd_word), .sda_oe(sda_oe),
    .ev_addr(ev_addr), .ev_track(ev_track), .ev_stop(ev_stop),
    .conv_start(conv_start), .ctrl_we(ctrl_we), .ctrl_byte(ctrl_byte),
    .rd_capture(rd_capture));

  daq_ctrl_decode u_dec (.ctrl_byte(ctrl_byte), .cfg(cfg_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      result_q <= '0;
      rd_word  <= '0;
    end else begin
      if (ctrl_we)     cfg_q    <= cfg_d;
      if (result_load) result_q <= result_data;
      if (rd_capture)  rd_word  <= result_q;
    end
  end

  assign cfg_chan    = cfg_q.chan;
  assign cfg_range   = cfg_q.range;
  assign cfg_bipolar = cfg_q.bipolar;
  assign cfg_pwr     = cfg_q.pwr;

  // R6
  marker_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |-> ctrl_byte[7]);
  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_we |=> $stable(cfg_q));
  // R11
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_capture |=> $stable(rd_word));
endmodule

// File: tb/test_daq_cmd_slave.sv
module test_daq_cmd_slave;
  localparam int HP = 10;

  logic clk = 0, rst = 1;
  logic scl = 1, sda_m = 1;
  logic [2:0] strap = 3'b101;
  logic [11:0] result_data = '0;
  logic result_load = 0;
  logic sda_oe, cfg_range, cfg_bipolar, ev_addr, ev_track, ev_stop, conv_start;
  logic [2:0] cfg_chan;
  logic [1:0] cfg_pwr;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  daq_cmd_slave i_daq_cmd_slave (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(strap), .result_data(result_data), .result_load(result_load),
    .cfg_chan(cfg_chan), .cfg_range(cfg_range), .cfg_bipolar(cfg_bipolar),
    .cfg_pwr(cfg_pwr), .ev_addr(ev_addr), .ev_track(ev_track),
    .ev_stop(ev_stop), .conv_start(conv_start));

  int checks = 0, failures = 0;
  int n_addr = 0, n_track = 0, n_stop = 0, n_conv = 0;
  int trk_pre = 0, trk_post = 0;
  bit cmp_on = 0, done = 0;
  logic [2:0] m_chan = 0;
  logic m_range = 0, m_bip = 0;
  logic [1:0] m_pwr = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: event counters and config compared on every clock
  always @(negedge clk) if (!rst) begin
    if (ev_addr) n_addr++;
    if (ev_track) n_track++;
    if (ev_stop) n_stop++;
    if (conv_start) n_conv++;
    if (cmp_on) begin
      check({cfg_chan, cfg_range, cfg_bipolar, cfg_pwr} == {m_chan, m_range, m_bip, m_pwr},
            "R4 R5 cfg model", {cfg_chan, cfg_range, cfg_bipolar, cfg_pwr},
            {m_chan, m_range, m_bip, m_pwr});
      check(sda_oe == 1'b0, "R3 idle release", sda_oe, 0);
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; scl = 1; tick(HP);
    sda_m = 0; tick(HP);
    scl = 0; tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(HP);
    scl = 1; tick(HP);
    sda_m = 1; tick(HP);
  endtask

  task automatic put_bit(input logic b);
    tick(2); sda_m = b; tick(HP);
    scl = 1; tick(HP);
    scl = 0;
  endtask

  task automatic get_bit(output logic b);
    tick(2); sda_m = 1; tick(HP);
    scl = 1; tick(HP/2);
    b = sda_line; tick(HP/2);
    scl = 0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      if (i == 2) trk_pre = n_track;
      put_bit(d[i]);
      if (i == 2) trk_post = n_track;
    end
    get_bit(ack);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      get_bit(b);
      d[i] = b;
    end
    put_bit(mack);
  endtask

  function automatic logic [1:0] pwr_of(input logic [1:0] pd);
    return pd[1] ? (pd[0] ? 2'd2 : 2'd1) : 2'd0;
  endfunction

  // Valid write with model update and event checks
  task automatic wr_ctrl(input logic [7:0] c, input string req);
    logic a;
    int a0, s0, v0;
    cmp_on = 0;
    a0 = n_addr; s0 = n_stop; v0 = n_conv;
    bus_start();
    send_byte({4'b0101, strap, 1'b0}, a);
    check(a == 0, "R2 addr ack", a, 0);
    check(n_addr == a0 + 1, "R2 ev_addr count", n_addr - a0, 1);
    send_byte(c, a);
    check(a == 0, {req, " ctrl ack"}, a, 0);
    check(trk_post - trk_pre == (c[7] ? 1 : 0), "R7 track window", trk_post - trk_pre, c[7]);
    bus_stop();
    check(n_stop == s0 + 1, "R8 ev_stop", n_stop - s0, 1);
    check(n_conv - v0 == (c[7] ? 1 : 0), "R8 R6 conv_start", n_conv - v0, c[7]);
    if (c[7]) begin
      m_chan = c[6:4]; m_range = c[3]; m_bip = c[2]; m_pwr = pwr_of(c[1:0]);
    end
    tick(4);
    cmp_on = 1;
    tick(HP);
  endtask

  task automatic rd_result(input logic [11:0] exp, input logic first_mack,
                           input bit extra, input logic [11:0] mid_load, input bit do_mid);
    logic a;
    logic [7:0] b0, b1, b2;
    cmp_on = 0;
    bus_start();
    send_byte({4'b0101, strap, 1'b1}, a);
    check(a == 0, "R9 read addr ack", a, 0);
    if (do_mid) begin
      result_data = mid_load; result_load = 1; tick(1); result_load = 0;
    end
    recv_byte(first_mack, b0);
    check(b0 == exp[11:4], "R9 R11 byte0", b0, exp[11:4]);
    recv_byte(1'b1, b1);
    check(b1 == {exp[3:0], 4'b0000}, "R9 R10 byte1", b1, {exp[3:0], 4'b0000});
    if (extra) begin
      recv_byte(1'b1, b2);
      check(b2 == 8'hFF, "R10 extra byte", b2, 8'hFF);
    end
    bus_stop();
    tick(4);
    cmp_on = 1;
    tick(HP);
  endtask

  initial begin
    logic a;
    int a0, s0, v0;
    tick(5); rst = 0; tick(5);
    // R1 reset state
    check({cfg_chan, cfg_range, cfg_bipolar, cfg_pwr} == 0, "R1 cfg reset",
          {cfg_chan, cfg_range, cfg_bipolar, cfg_pwr}, 0);
    check(sda_oe == 0, "R1 sda released", sda_oe, 0);
    cmp_on = 1;
    rd_result(12'h000, 1'b0, 0, 12'h0, 0);              // R1 cleared result
    wr_ctrl(8'hBE, "R4");                               // chan3 rng bip standby R5
    wr_ctrl(8'hC1, "R5");                               // chan4 normal
    wr_ctrl(8'hF7, "R5");                               // chan7 bip full
    wr_ctrl(8'h3F, "R6");                               // marker clear: ignored
    // R3 mismatched addresses, then a byte that must be ignored
    for (int k = 0; k < 2; k++) begin
      cmp_on = 0;
      a0 = n_addr; s0 = n_stop; v0 = n_conv;
      bus_start();
      send_byte(k == 0 ? 8'h5C : 8'h7A, a);
      check(a == 1, "R3 no addr ack", a, 1);
      send_byte(8'h80, a);
      check(a == 1, "R3 byte ignored", a, 1);
      bus_stop();
      check(n_addr == a0, "R3 no ev_addr", n_addr - a0, 0);
      check(n_conv == v0, "R3 no conv", n_conv - v0, 0);
      check(n_stop == s0 + 1, "R8 stop after mismatch", n_stop - s0, 1);
      tick(4); cmp_on = 1; tick(HP);
    end
    // R9 result path
    result_data = 12'hA5C; result_load = 1; tick(1); result_load = 0; tick(2);
    rd_result(12'hA5C, 1'b0, 0, 12'h0, 0);
    rd_result(12'hA5C, 1'b1, 1, 12'h0, 0);              // R10 NACK then extra
    rd_result(12'hA5C, 1'b0, 0, 12'h123, 1);            // R11 load during read
    rd_result(12'h123, 1'b0, 0, 12'h0, 0);              // R11 next read new value
    // R2 another strap value
    strap = 3'b000; tick(2);
    wr_ctrl(8'h92, "R2");
    rd_result(12'h123, 1'b0, 0, 12'h0, 0);
    cmp_on = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule